// File: doc/BRIEF.md
# Camera Link Deserializer Receiver

This block is the receiving end of a two-line serial camera link: one clock line and one data line. It sees the lines as states sampled on a system clock that runs at least twice per link-clock period. Each sample gives three bits: whether the clock line carries current, the clock line level and the data line level. The receiver tracks the link's off, initialization and active phases. It locks onto the low/high/low initialization pattern on the clock line. From the first rising edge that follows, it takes one data bit on every clock-line edge.

Every ten bits form one word, least significant bit first. The receiver turns each word into eight pixel bits, a vertical sync and a horizontal sync, and marks each completed word with a one-cycle pixel-clock pulse. An active-low power-down input, and any mode code other than the receiver code, force every parallel output low and hold the framer in the off phase.

Top module: `mlink_rx`

## Requirements
- R1: The block operates only when `mode` is 2'b00. For codes 01, 10 and 11, every parallel output is low, the framer is held off and no word is produced, whatever the lines do.
- R2: While `pwr_n` is low, `pix_dat_o`, `vsync_o`, `hsync_o` and `pix_clk_o` are low in the same cycle, and the framer returns to off. After `pwr_n` rises again, no word is produced until a new valid initialization pattern arrives.
- R3: A clock-line initialization is accepted when each of its three phases lasts between PH_MIN*CYC_DIV and PH_MAX*CYC_DIV samples (22 to 26 with the defaults), inclusive at both ends. The phases are a low run that starts on a falling edge or right after the line turns on, then a high run, then a low run.
- R4: If any phase of the initialization is shorter or longer than that window, the receiver goes back to searching. It produces no word until a complete valid pattern follows, and it keeps the last word on its outputs.
- R5: The first rising clock-line edge after the second low phase carries bit 0. Every later edge, rising or falling, carries the next bit. In each ten-bit word, bits 0 to 7 are the pixel data (bit 0 is `pix_dat_o[0]`), bit 8 is VSYNC and bit 9 is HSYNC.
- R6: `pix_clk_o` goes high for exactly one cycle per completed word. It does so in the second system-clock cycle after the line sample holding bit 9 is presented, and the data and sync outputs take the new word in that same cycle and change at no other time except when cleared.
- R7: If the clock line goes to the off state (`ln_clk_on` low) while active, the receiver drops to the off phase and discards any partial word. Later clock-line edges produce no word until a new valid initialization pattern arrives.
- R8: While `rst_n` is low, all outputs are low and the framer is in the off phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock, at least CYC_DIV samples per link-clock period |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_n | input | 1 | Active-low power-down |
| mode | input | 2 | Function select; 2'b00 selects the receiver |
| ln_clk_on | input | 1 | Clock line carries current (0 = link off) |
| ln_clk | input | 1 | Sampled clock-line level |
| ln_dat | input | 1 | Sampled data-line level |
| pix_dat_o | output | DAT_W | Rebuilt pixel data |
| vsync_o | output | 1 | Rebuilt vertical sync |
| hsync_o | output | 1 | Rebuilt horizontal sync |
| pix_clk_o | output | 1 | One-cycle pulse per delivered word |

## Verification
The line inputs pass through one sampling register, and the decoded word is registered once more. A word's outputs and its pixel-clock pulse are therefore due on the second rising edge after the sample holding bit 9 is driven. The bench drives every line sample on a falling edge and holds the lines still after the last bit. It reads the outputs on the first following falling edge, where the pulse must still be low, then on the second, where the full word must be present, and then on the third, where the pulse must be low again. The power-down and mode gates act on the outputs without delay, so those checks read the outputs one time step after the input changes.

// File: rtl/mlr_pkg.sv
package mlr_pkg;

   // Framer phases
   typedef enum logic [2:0] {
      ST_OFF  = 3'd0,
      ST_SRCH = 3'd1,
      ST_LO1  = 3'd2,
      ST_HI   = 3'd3,
      ST_LO2  = 3'd4,
      ST_ACT  = 3'd5
   } rx_st_e;

   localparam logic [1:0] MODE_RX = 2'b00;

endpackage

// File: rtl/mlr_sampler.sv
module mlr_sampler #(
   parameter int STAGES = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic on_i,
   input  logic lvl_i,
   input  logic dat_i,
   output logic on_o,
   output logic lvl_o,
   output logic lvl_prev_o,
   output logic dat_o
);

   initial assert (STAGES >= 1) else $error("mlr_sampler: STAGES must be at least 1");

   logic [2:0] tap;
   logic       prev_q;

   generate
      if (STAGES == 1) begin : g_one
         logic [2:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= '0;
            else        q <= {on_i, lvl_i, dat_i};
         end
         assign tap = q;
      end else begin : g_chain
         logic [2:0] q [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) q[i] <= '0;
            end else begin
               q[0] <= {on_i, lvl_i, dat_i};
               for (int i = 1; i < STAGES; i++) q[i] <= q[i-1];
            end
         end
         assign tap = q[STAGES-1];
      end
   endgenerate

   // previous clock-line level for edge detection
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= tap[1];
   end

   assign on_o       = tap[2];
   assign lvl_o      = tap[1];
   assign dat_o      = tap[0];
   assign lvl_prev_o = prev_q;

endmodule

// File: rtl/mlr_framer.sv
module mlr_framer
   import mlr_pkg::*;
#(
   parameter int CYC_DIV = 2,
   parameter int PH_MIN  = 11,
   parameter int PH_MAX  = 13
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_en,
   input  logic on_i,
   input  logic lvl_i,
   input  logic lvl_prev_i,
   output logic act_o,
   output logic stb_o,
   output logic first_o
);

   localparam int MIN_S = PH_MIN * CYC_DIV;
   localparam int MAX_S = PH_MAX * CYC_DIV;
   localparam int CNT_W = $clog2(MAX_S + 2);

   initial assert (CYC_DIV >= 2) else $error("mlr_framer: CYC_DIV must be at least 2");
   initial assert (PH_MIN >= 1 && PH_MAX >= PH_MIN) else $error("mlr_framer: bad phase window");

   rx_st_e             st_q, st_n;
   logic [CNT_W-1:0]   cnt_q, cnt_n, cnt_inc;
   logic               rise, fall, edge_any, in_win;

   assign rise     = lvl_i & ~lvl_prev_i;
   assign fall     = ~lvl_i & lvl_prev_i;
   assign edge_any = rise | fall;
   assign in_win   = (cnt_q >= CNT_W'(MIN_S)) && (cnt_q <= CNT_W'(MAX_S));
   assign cnt_inc  = (cnt_q == CNT_W'(MAX_S + 1)) ? cnt_q : cnt_q + CNT_W'(1);

   always_comb begin
      st_n    = st_q;
      cnt_n   = cnt_q;
      stb_o   = 1'b0;
      first_o = 1'b0;
      if (!run_en || !on_i) begin
         st_n  = ST_OFF;
         cnt_n = '0;
      end else begin
         case (st_q)
            ST_OFF: begin
               if (!lvl_i) begin
                  st_n  = ST_LO1;
                  cnt_n = CNT_W'(1);
               end else begin
                  st_n = ST_SRCH;
               end
            end
            ST_SRCH: begin
               if (fall) begin
                  st_n  = ST_LO1;
                  cnt_n = CNT_W'(1);
               end
            end
            ST_LO1: begin
               if (!lvl_i)      cnt_n = cnt_inc;
               else if (in_win) begin
                  st_n  = ST_HI;
                  cnt_n = CNT_W'(1);
               end else         st_n = ST_SRCH;
            end
            ST_HI: begin
               if (lvl_i)       cnt_n = cnt_inc;
               else if (in_win) begin
                  st_n  = ST_LO2;
                  cnt_n = CNT_W'(1);
               end else         st_n = ST_SRCH;
            end
            ST_LO2: begin
               if (!lvl_i)      cnt_n = cnt_inc;
               else if (in_win) begin
                  st_n    = ST_ACT;
                  cnt_n   = '0;
                  stb_o   = 1'b1;
                  first_o = 1'b1;
               end else         st_n = ST_SRCH;
            end
            ST_ACT: begin
               stb_o = edge_any;
            end
            default: begin
               st_n  = ST_OFF;
               cnt_n = '0;
            end
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= ST_OFF;
         cnt_q <= '0;
      end else begin
         st_q  <= st_n;
         cnt_q <= cnt_n;
      end
   end

   assign act_o = (st_q == ST_ACT);

   // R2
   pd_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run_en |=> st_q == ST_OFF);

   // R7
   line_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !on_i |=> st_q == ST_OFF);

   // R4
   act_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_ACT && $past(st_q) != ST_ACT) |-> $past(st_q) == ST_LO2);

   // R3
   win_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_HI && $past(st_q) == ST_LO1) |->
         ($past(cnt_q) >= CNT_W'(MIN_S) && $past(cnt_q) <= CNT_W'(MAX_S)));

endmodule

// File: rtl/mlr_deframe.sv
module mlr_deframe #(
   parameter int DAT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_en,
   input  logic             act_i,
   input  logic             stb_i,
   input  logic             first_i,
   input  logic             dat_i,
   output logic [DAT_W-1:0] dat_o,
   output logic             vs_o,
   output logic             hs_o,
   output logic             pix_o
);

   localparam int WORD_W = DAT_W + 2;
   localparam int BC_W   = $clog2(WORD_W);

   initial assert (DAT_W >= 1) else $error("mlr_deframe: DAT_W must be at least 1");

   logic [WORD_W-1:0] sh_q, word_n, out_q;
   logic [BC_W-1:0]   bcnt_q, idx;
   logic              pix_q, last_bit;

   assign idx      = first_i ? '0 : bcnt_q;
   assign last_bit = (idx == BC_W'(WORD_W - 1));

   always_comb begin
      word_n      = sh_q;
      word_n[idx] = dat_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q   <= '0;
         bcnt_q <= '0;
         out_q  <= '0;
         pix_q  <= 1'b0;
      end else if (!run_en) begin
         sh_q   <= '0;
         bcnt_q <= '0;
         out_q  <= '0;
         pix_q  <= 1'b0;
      end else begin
         pix_q <= 1'b0;
         if (stb_i) begin
            sh_q <= word_n;
            if (last_bit) begin
               out_q  <= word_n;
               pix_q  <= 1'b1;
               bcnt_q <= '0;
            end else begin
               bcnt_q <= idx + BC_W'(1);
            end
         end else if (!act_i) begin
            bcnt_q <= '0;
         end
      end
   end

   assign dat_o = out_q[DAT_W-1:0];
   assign vs_o  = out_q[DAT_W];
   assign hs_o  = out_q[DAT_W+1];
   assign pix_o = pix_q;

   // R6
   pix_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pix_q |=> !pix_q);

   // R1
   quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run_en |=> !pix_q);

   // R6
   dat_upd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(run_en) && !$stable(out_q)) |-> pix_q);

endmodule

// File: rtl/mlink_rx.sv
module mlink_rx
   import mlr_pkg::*;
#(
   parameter int DAT_W       = 8,
   parameter int CYC_DIV     = 2,
   parameter int PH_MIN      = 11,
   parameter int PH_MAX      = 13,
   parameter int SYNC_STAGES = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pwr_n,
   input  logic [1:0]       mode,
   input  logic             ln_clk_on,
   input  logic             ln_clk,
   input  logic             ln_dat,
   output logic [DAT_W-1:0] pix_dat_o,
   output logic             vsync_o,
   output logic             hsync_o,
   output logic             pix_clk_o
);

   logic             run_en;
   logic             s_on, s_lvl, s_prev, s_dat;
   logic             f_act, f_stb, f_first;
   logic [DAT_W-1:0] w_dat;
   logic             w_vs, w_hs, w_pix;

   assign run_en = pwr_n && (mode == MODE_RX);

   mlr_sampler #(.STAGES(SYNC_STAGES)) u_smp (
      .clk        (clk),
      .rst_n      (rst_n),
      .on_i       (ln_clk_on),
      .lvl_i      (ln_clk),
      .dat_i      (ln_dat),
      .on_o       (s_on),
      .lvl_o      (s_lvl),
      .lvl_prev_o (s_prev),
      .dat_o      (s_dat)
   );

   mlr_framer #(.CYC_DIV(CYC_DIV), .PH_MIN(PH_MIN), .PH_MAX(PH_MAX)) u_frm (
      .clk        (clk),
      .rst_n      (rst_n),
      .run_en     (run_en),
      .on_i       (s_on),
      .lvl_i      (s_lvl),
      .lvl_prev_i (s_prev),
      .act_o      (f_act),
      .stb_o      (f_stb),
      .first_o    (f_first)
   );

   mlr_deframe #(.DAT_W(DAT_W)) u_dfr (
      .clk     (clk),
      .rst_n   (rst_n),
      .run_en  (run_en),
      .act_i   (f_act),
      .stb_i   (f_stb),
      .first_i (f_first),
      .dat_i   (s_dat),
      .dat_o   (w_dat),
      .vs_o    (w_vs),
      .hs_o    (w_hs),
      .pix_o   (w_pix)
   );

   // outputs forced low at once in power-down or a non-receiver mode
   assign pix_dat_o = run_en ? w_dat : '0;
   assign vsync_o   = run_en & w_vs;
   assign hsync_o   = run_en & w_hs;
   assign pix_clk_o = run_en & w_pix;

endmodule

// File: tb/mlink_rx_tb.sv
module mlink_rx_tb;

   localparam int CLK_PER = 10;

   logic       clk = 1'b0;
   logic       rst_n, pwr_n, ln_clk_on, ln_clk, ln_dat, lvl;
   logic [1:0] mode;
   logic [7:0] pix_dat_o;
   logic       vsync_o, hsync_o, pix_clk_o;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   // words sent after a valid initialization; expected fields are
   // data = bits 7:0, VSYNC = bit 8, HSYNC = bit 9
   localparam logic [9:0] VEC [6] = '{10'h3FF, 10'h000, 10'h155, 10'h2AA, 10'h1A5, 10'h25A};

   always #(CLK_PER/2) clk = ~clk;

   mlink_rx u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .pwr_n     (pwr_n),
      .mode      (mode),
      .ln_clk_on (ln_clk_on),
      .ln_clk    (ln_clk),
      .ln_dat    (ln_dat),
      .pix_dat_o (pix_dat_o),
      .vsync_o   (vsync_o),
      .hsync_o   (hsync_o),
      .pix_clk_o (pix_clk_o)
   );

   function automatic logic [10:0] outs();
      return {pix_clk_o, hsync_o, vsync_o, pix_dat_o};
   endfunction

   task automatic check(input string req, input logic [10:0] act, input logic [10:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic put(input logic on, input logic c, input logic d);
      @(negedge clk);
      ln_clk_on = on;
      ln_clk    = c;
      ln_dat    = d;
   endtask

   task automatic link_init(input int lo1, input int hi, input int lo2);
      repeat (2)   put(1'b0, 1'b0, 1'b0);
      repeat (3)   put(1'b1, 1'b1, 1'b0);
      repeat (lo1) put(1'b1, 1'b0, 1'b0);
      repeat (hi)  put(1'b1, 1'b1, 1'b0);
      repeat (lo2) put(1'b1, 1'b0, 1'b0);
      lvl = 1'b0;
   endtask

   // ten bits, one per clock-line edge, then outputs read at the due cycle
   task automatic send_word(input logic [9:0] w, input logic got, input logic [9:0] shown,
                            input string req);
      for (int i = 0; i < 10; i++) begin
         lvl = ~lvl;
         put(1'b1, lvl, w[i]);
      end
      @(negedge clk);
      check("R6 pulse not early", {10'h0, pix_clk_o}, 11'h0);
      @(negedge clk);
      check(req, outs(), {got, shown});
      @(negedge clk);
      check("R6 pulse one cycle", {10'h0, pix_clk_o}, 11'h0);
   endtask

   initial begin
      rst_n = 1'b0; pwr_n = 1'b1; mode = 2'b00;
      ln_clk_on = 1'b0; ln_clk = 1'b0; ln_dat = 1'b0; lvl = 1'b0;
      repeat (4) @(negedge clk);
      check("R8 reset outputs", outs(), 11'h0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R8 idle after reset", outs(), 11'h0);

      // R5 / R6: table of words after nominal initialization
      link_init(24, 24, 24);
      for (int i = 0; i < 6; i++) send_word(VEC[i], 1'b1, VEC[i], "R5 word");

      // R3: window boundaries
      link_init(22, 26, 22);
      send_word(10'h2C3, 1'b1, 10'h2C3, "R3 min/max edges");
      link_init(26, 22, 26);
      send_word(10'h13C, 1'b1, 10'h13C, "R3 max/min edges");

      // R4: out-of-window phases
      link_init(20, 24, 24);
      send_word(10'h0F0, 1'b0, 10'h13C, "R4 short low");
      link_init(24, 28, 24);
      send_word(10'h0F0, 1'b0, 10'h13C, "R4 long high");
      link_init(24, 24, 27);
      send_word(10'h0F0, 1'b0, 10'h13C, "R4 long second low");
      link_init(24, 24, 24);
      send_word(10'h0F0, 1'b1, 10'h0F0, "R4 recovery");

      // R7: clock line turns off while active
      repeat (3) put(1'b0, lvl, 1'b0);
      send_word(10'h155, 1'b0, 10'h0F0, "R7 no word after line off");

      // R1: non-receiver modes
      mode = 2'b01;
      link_init(24, 24, 24);
      send_word(10'h2AA, 1'b0, 10'h000, "R1 mode 01");
      mode = 2'b11;
      link_init(24, 24, 24);
      send_word(10'h2AA, 1'b0, 10'h000, "R1 mode 11");
      mode = 2'b00;
      link_init(24, 24, 24);
      send_word(10'h2AA, 1'b1, 10'h2AA, "R1 back to receiver");

      // R2: power-down forces outputs low at once and resets framing
      @(negedge clk);
      pwr_n = 1'b0;
      #1;
      check("R2 outputs low in power-down", outs(), 11'h0);
      repeat (3) @(negedge clk);
      pwr_n = 1'b1;
      send_word(10'h3C3, 1'b0, 10'h000, "R2 no word without init");

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule